// File: doc/BRIEF.md
# Supervisor Count-Compare Timer

This block keeps a 64-bit event count and a 32-bit compare value, and raises a sticky timer-pending flag for supervisor software once the low 32 bits of the count pass the compare value. Every cycle the count grows by an increment of 0 to 255, the number of instructions retired in that cycle. Because one cycle can move the count by many steps, the match is not a test for equality. The block forms the signed distance from the compare value before the step and after it, and sets the flag when that distance changes sign. A count that jumps over the compare value in a single cycle therefore still raises the flag.

A small register port writes the whole count, writes only its upper half, or writes the compare value. Writing the compare value also clears the flag. The read port returns the whole count, its upper half or the compare value. In wide mode a read of the upper half is refused. The block also gives an instruction stepper a budget: the number of counts left before the compare point, forced odd so that it is never zero.

Top module: `sup_tick_timer`

## Requirements
- R1: After reset the count is 0, the compare value is 0 and `timerPending` is 0.
- R2: With no write to the count, the count grows by `incAmount` (0..255) at each rising clock edge and wraps modulo 2^64.
- R3: A write with `wrSel`=0 loads all 64 bits of `wrData` into the count. The increment of that cycle is dropped and the flag is left as it is.
- R4: A write with `wrSel`=1 loads `wrData[31:0]` into count bits 63:32 and keeps count bits 31:0. The increment of that cycle is dropped.
- R5: A write with `wrSel`=2 loads `wrData[31:0]` into the compare value and clears `timerPending`. The count still grows by that cycle's increment, and no crossing is tested in that cycle.
- R6: In a cycle with no write of `wrSel` 0, 1 or 2, `timerPending` is set at the edge if the 64-bit difference (low32(count) − compare) changes sign when the increment is added. That is the case exactly when low32 < compare and compare − low32 ≤ increment, which includes stepping past the compare value. A low half that wraps through zero from above the compare value does not set the flag.
- R7: `timerPending` is sticky. Only a compare write (R5) or reset clears it.
- R8: `remaining` equals ((compare − low32(count)) mod 2^32) OR 1, so it is never 0.
- R9: `rdSel`=0 reads the full count and `rdSel`=2 reads the compare value, zero-extended. `rdSel`=3 is illegal: `rdIllegal`=1 and `rdData`=0.
- R10: `rdSel`=1 with `WIDE_MODE`=1 is illegal (`rdIllegal`=1, `rdData`=0). With `WIDE_MODE`=0 it returns count bits 63:32 in `rdData[31:0]`, with `rdIllegal`=0.
- R11: A write with `wrSel`=3 has no effect. The count still advances, and the crossing test still applies as in a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| incAmount | input | 8 | Count increment for this cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 count, 1 upper half, 2 compare, 3 none |
| wrData | input | 64 | Write data |
| rdSel | input | 2 | Read target: 0 count, 1 upper half, 2 compare, 3 illegal |
| rdData | output | 64 | Read data, combinational |
| rdIllegal | output | 1 | Read target refused |
| timerPending | output | 1 | Sticky timer-pending flag |
| remaining | output | 32 | Counts left to the compare point, forced odd |

## Verification
The crossing test is driven with increments that land exactly on the compare value, with increments that overshoot it by a wide margin, and with a count that already equals or exceeds the compare value. Together these separate a sign-change detector from an equality match and from a test off by one count. Further directed cases wrap the low half through zero above the compare value, and wrap the full 64-bit count. Seeded random stimulus then mixes all four write targets with increments across the full range, and checks the count, the flag and the remaining budget after every edge against a model built on the plain inequality form of the crossing rule. A second instance in narrow mode tells the upper-half read apart from the refused read of wide mode.

// File: rtl/sup_tick_pkg.sv
package sup_tick_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_CMP   = 2'd2,
    SEL_RSVD  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntWr;    // replace whole count
    logic hiWr;     // replace upper half of count
    logic cmpWr;    // load compare, clear pending
    logic advance;  // add this cycle's increment
    logic crossEn;  // evaluate the crossing test
  } tickStrobe_t;

  typedef struct packed {
    logic pickCount;
    logic pickHigh;
    logic pickCmp;
    logic illegal;
  } readPick_t;

endpackage

// File: rtl/sup_tick_ctrl.sv
module sup_tick_ctrl
  import sup_tick_pkg::*;
#(
  parameter bit WIDE_MODE = 1'b1
) (
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [1:0]  rdSel,
  output tickStrobe_t strb,
  output readPick_t   pick
);

  regSel_e wrKind;
  regSel_e rdKind;

  assign wrKind = regSel_e'(wrSel);
  assign rdKind = regSel_e'(rdSel);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wrKind)
        SEL_COUNT: strb.cntWr = 1'b1;
        SEL_HIGH:  strb.hiWr  = 1'b1;
        SEL_CMP:   strb.cmpWr = 1'b1;
        default:   ;
      endcase
    end
    strb.advance = !(strb.cntWr || strb.hiWr);
    strb.crossEn = !(strb.cntWr || strb.hiWr || strb.cmpWr);
  end

  always_comb begin
    pick = '0;
    unique case (rdKind)
      SEL_COUNT: pick.pickCount = 1'b1;
      SEL_HIGH: begin
        if (WIDE_MODE) pick.illegal  = 1'b1;
        else           pick.pickHigh = 1'b1;
      end
      SEL_CMP:   pick.pickCmp = 1'b1;
      default:   pick.illegal = 1'b1;
    endcase
  end

  // R3 R4 R5: at most one write target per cycle
  always_comb begin
    assert_one_target_R5: assert ($onehot0({strb.cntWr, strb.hiWr, strb.cmpWr}))
      else $error("more than one write target");
    // R9 R10: exactly one read choice
    assert_one_read_R9: assert ($countones({pick.pickCount, pick.pickHigh, pick.pickCmp, pick.illegal}) == 1)
      else $error("read choice not unique");
  end

endmodule

// File: rtl/sup_tick_cross.sv
module sup_tick_cross #(
  parameter int CNT_W = 64,
  parameter int CMP_W = 32,
  parameter int INC_W = 8
) (
  input  logic [CMP_W-1:0] lowCount,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic [INC_W-1:0] incAmount,
  output logic             crossHit,
  output logic [CMP_W-1:0] remaining
);

  localparam int PAD_CMP = CNT_W - CMP_W;
  localparam int PAD_INC = CNT_W - INC_W;

  logic [CNT_W-1:0] distBefore;
  logic [CNT_W-1:0] distAfter;

  // signed distance from the compare point, wide enough never to wrap
  assign distBefore = {{PAD_CMP{1'b0}}, lowCount} - {{PAD_CMP{1'b0}}, cmpVal};
  assign distAfter  = distBefore + {{PAD_INC{1'b0}}, incAmount};
  assign crossHit   = distBefore[CNT_W-1] ^ distAfter[CNT_W-1];

  // stepper budget, kept odd so it is never zero
  assign remaining  = (cmpVal - lowCount) | {{(CMP_W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/sup_tick_dp.sv
module sup_tick_dp
  import sup_tick_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int CMP_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tickStrobe_t      strb,
  input  readPick_t        pick,
  input  logic [INC_W-1:0] incAmount,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             timerPending,
  output logic [CMP_W-1:0] remaining
);

  localparam int HI_W = CNT_W - CMP_W;

  logic [CNT_W-1:0] countQ;
  logic [CMP_W-1:0] cmpQ;
  logic             pendingQ;
  logic             crossHit;
  logic [CNT_W-1:0] incExt;

  assign incExt = {{(CNT_W-INC_W){1'b0}}, incAmount};

  sup_tick_cross #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W),
    .INC_W (INC_W)
  ) u_cross (
    .lowCount  (countQ[CMP_W-1:0]),
    .cmpVal    (cmpQ),
    .incAmount (incAmount),
    .crossHit  (crossHit),
    .remaining (remaining)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strb.cntWr) begin
      countQ <= wrData;
    end else if (strb.hiWr) begin
      countQ <= {wrData[HI_W-1:0], countQ[CMP_W-1:0]};
    end else if (strb.advance) begin
      countQ <= countQ + incExt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpQ     <= '0;
      pendingQ <= 1'b0;
    end else if (strb.cmpWr) begin
      cmpQ     <= wrData[CMP_W-1:0];
      pendingQ <= 1'b0;
    end else if (strb.crossEn && crossHit) begin
      pendingQ <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (pick.pickCount) rdData = countQ;
    else if (pick.pickHigh) rdData = {{CMP_W{1'b0}}, countQ[CNT_W-1:CMP_W]};
    else if (pick.pickCmp) rdData = {{HI_W{1'b0}}, cmpQ};
  end

  assign timerPending = pendingQ;

  assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntWr |=> countQ == $past(wrData))
    else $error("count write not loaded");

  assert_low_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hiWr |=> countQ[CMP_W-1:0] == $past(countQ[CMP_W-1:0]))
    else $error("upper-half write disturbed low half");

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.advance |=> countQ == $past(countQ) + $past(incExt))
    else $error("count did not advance by increment");

  assert_cmp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cmpWr |=> !pendingQ)
    else $error("compare write did not clear pending");

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pendingQ && !strb.cmpWr |=> pendingQ)
    else $error("pending dropped without compare write");

  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendingQ) |-> $past(strb.crossEn && crossHit))
    else $error("pending set without a crossing");

endmodule

// File: rtl/sup_tick_timer.sv
module sup_tick_timer
  import sup_tick_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int CMP_W     = 32,
  parameter int INC_W     = 8,
  parameter bit WIDE_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] incAmount,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             rdIllegal,
  output logic             timerPending,
  output logic [CMP_W-1:0] remaining
);

  tickStrobe_t strb;
  readPick_t   pick;

  sup_tick_ctrl #(
    .WIDE_MODE (WIDE_MODE)
  ) u_ctrl (
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .rdSel (rdSel),
    .strb  (strb),
    .pick  (pick)
  );

  sup_tick_dp #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W),
    .INC_W (INC_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .pick         (pick),
    .incAmount    (incAmount),
    .wrData       (wrData),
    .rdData       (rdData),
    .timerPending (timerPending),
    .remaining    (remaining)
  );

  assign rdIllegal = pick.illegal;

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdIllegal |-> rdData == '0)
    else $error("refused read returned data");

  assert_budget_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    remaining != '0)
    else $error("stepper budget is zero");

endmodule

// File: tb/sup_tick_timer_tb.sv
module sup_tick_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  incAmount = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [63:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [63:0] rdData;
  logic        rdIllegal;
  logic        timerPending;
  logic [31:0] remaining;

  logic [63:0] rdData32;
  logic        rdIllegal32;
  logic        pend32;
  logic [31:0] rem32;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [63:0] mCnt;
  logic [31:0] mCmp;
  logic        mPend;

  always #4 clk = ~clk;

  sup_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .incAmount(incAmount), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .rdIllegal(rdIllegal),
    .timerPending(timerPending), .remaining(remaining)
  );

  sup_tick_timer #(.WIDE_MODE(1'b0)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .incAmount(incAmount), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(2'd1), .rdData(rdData32), .rdIllegal(rdIllegal32),
    .timerPending(pend32), .remaining(rem32)
  );

  function automatic bit expCross(input logic [31:0] low, input logic [31:0] cmp,
                                  input logic [7:0] inc);
    return (low < cmp) && ((cmp - low) <= {24'd0, inc});
  endfunction

  function automatic logic [31:0] expRemain(input logic [63:0] cnt, input logic [31:0] cmp);
    return (cmp - cnt[31:0]) | 32'd1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, return at next negedge
  task automatic cycle(input logic [7:0] i, input logic w, input logic [1:0] s,
                       input logic [63:0] d);
    incAmount = i; wrEn = w; wrSel = s; wrData = d;
    @(posedge clk);
    if (w && s == 2'd0) begin
      mCnt = d;
    end else if (w && s == 2'd1) begin
      mCnt = {d[31:0], mCnt[31:0]};
    end else begin
      if (w && s == 2'd2) begin
        mCmp = d[31:0];
        mPend = 1'b0;
      end else if (expCross(mCnt[31:0], mCmp, i)) begin
        mPend = 1'b1;
      end
      mCnt = mCnt + {56'd0, i};
    end
    @(negedge clk);
    incAmount = '0; wrEn = 1'b0;
    #1;
  endtask

  task automatic checkAll(input string tagCnt, input string tagPend);
    rdSel = 2'd0; #1;
    chk(tagCnt, rdData, mCnt);
    chk(tagPend, {63'd0, timerPending}, {63'd0, mPend});
    chk("R8 remaining", {32'd0, remaining}, {32'd0, expRemain(mCnt, mCmp)});
    chk("R10 narrow high read", rdData32, {32'd0, mCnt[63:32]});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    mCnt = '0; mCmp = '0; mPend = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    rdSel = 2'd0; #1;
    chk("R1 count", rdData, 64'd0);
    chk("R1 pending", {63'd0, timerPending}, 64'd0);
    rdSel = 2'd2; #1;
    chk("R1 compare", rdData, 64'd0);

    // R9 reads
    rdSel = 2'd3; #1;
    chk("R9 rsvd illegal", {63'd0, rdIllegal}, 64'd1);
    chk("R9 rsvd data", rdData, 64'd0);
    rdSel = 2'd1; #1;
    chk("R10 wide high illegal", {63'd0, rdIllegal}, 64'd1);
    chk("R10 wide high data", rdData, 64'd0);
    chk("R10 narrow legal", {63'd0, rdIllegal32}, 64'd0);

    // R5 compare load, then R3 count load
    cycle(8'd3, 1'b1, 2'd2, 64'hFFFF_FFFF_0000_0064);
    rdSel = 2'd2; #1;
    chk("R5 compare loaded", rdData, 64'h64);
    checkAll("R5 count advanced", "R5 pending clear");
    cycle(8'd9, 1'b1, 2'd0, 64'h0000_0007_0000_005A);
    checkAll("R3 full load drops inc", "R3 pending kept");

    // R6 exact landing: 90 + 10 = 100
    cycle(8'd10, 1'b0, 2'd0, 64'd0);
    chk("R6 exact landing", {63'd0, timerPending}, 64'd1);
    checkAll("R2 count", "R6 pending");
    // R7 sticky under further counting and ignored write
    cycle(8'd200, 1'b0, 2'd0, 64'd0);
    cycle(8'd1, 1'b1, 2'd3, 64'hDEAD);
    chk("R7 sticky", {63'd0, timerPending}, 64'd1);
    checkAll("R11 rsvd write counts", "R7 pending");
    // R5 clears
    cycle(8'd0, 1'b1, 2'd2, 64'd1000);
    chk("R5 cleared", {63'd0, timerPending}, 64'd0);

    // R6 one below: count at compare-11, inc 10 -> no
    cycle(8'd0, 1'b1, 2'd0, 64'd989);
    cycle(8'd10, 1'b0, 2'd0, 64'd0);
    chk("R6 short of compare", {63'd0, timerPending}, 64'd0);
    // R8 at compare-1: remaining 1
    chk("R8 one left", {32'd0, remaining}, 64'd1);
    // overshoot by a wide margin
    cycle(8'd255, 1'b0, 2'd0, 64'd0);
    chk("R6 overshoot", {63'd0, timerPending}, 64'd1);
    checkAll("R2 count", "R6 pending");

    // R6 starting on compare: no set
    cycle(8'd0, 1'b1, 2'd2, 64'd50);
    cycle(8'd0, 1'b1, 2'd0, 64'd50);
    chk("R8 at compare", {32'd0, remaining}, 64'd1);
    cycle(8'd255, 1'b0, 2'd0, 64'd0);
    chk("R6 start at compare", {63'd0, timerPending}, 64'd0);

    // R6 low half wraps through zero from above compare: no set
    cycle(8'd0, 1'b1, 2'd2, 64'd5);
    cycle(8'd0, 1'b1, 2'd0, 64'h0000_0001_FFFF_FFF0);
    cycle(8'd255, 1'b0, 2'd0, 64'd0);
    chk("R6 low wrap no set", {63'd0, timerPending}, 64'd0);
    checkAll("R2 carry into high", "R6 pending");

    // R2 64-bit wrap
    cycle(8'd0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    cycle(8'h20, 1'b0, 2'd0, 64'd0);
    rdSel = 2'd0; #1;
    chk("R2 64-bit wrap", rdData, 64'h10);

    // R4 upper-half write keeps low, drops inc
    cycle(8'd7, 1'b1, 2'd1, 64'hAAAA_BBBB_0000_1234);
    rdSel = 2'd0; #1;
    chk("R4 upper write", rdData, 64'h0000_1234_0000_0010);
    checkAll("R4 count", "R4 pending");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  ri;
      logic        rw;
      logic [1:0]  rs;
      logic [63:0] rd;
      ri = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 16);
      rw = ($urandom % 12 == 0);
      rs = 2'($urandom % 4);
      rd = {$urandom, $urandom};
      if (rs == 2'd0 && ($urandom % 2 == 0)) rd[31:0] = mCmp - 32'($urandom % 300);
      if (rs == 2'd2 && ($urandom % 2 == 0)) rd[31:0] = mCnt[31:0] + 32'($urandom % 300);
      cycle(ri, rw, rs, rd);
      checkAll("R2 random count", "R6 random pending");
    end

    summary();
  end

endmodule